// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing side of a 16K-byte serial EEPROM hanging on a two-wire bus. It watches the oversampled clock and data lines for start and stop conditions and shifts in the first byte after each start. That byte carries a fixed four-bit device code, three select bits that must match the strap pins, and a direction bit. The controller answers only when the device code and select bits both match, so up to eight such devices can share one bus.

After a write-direction selection it takes a two-byte word pointer, high byte first, and then passes each following data byte to a synchronous byte-wide memory port. After a read-direction selection it fetches bytes from that port and shifts them out most significant bit first. The read continues for as long as the bus master acknowledges. It starts at the current pointer, which can be set by a write-direction selection that carries only the pointer, followed by a repeated start. The storage array, program timing and pad drivers live outside this block.

Top module: `eeprom_twi_slave`

## Requirements
- R1: While reset is held, and on the first cycle after it, the block does not drive the data line (`sda_oe` = 0) and raises neither `mem_we` nor `mem_re`.
- R2: A byte after a start whose bits 7..4 equal 1010 and whose bits 3..1 equal `sel_pins` (bit 3 = `sel_pins[2]`) is acknowledged: the data line is held low during the ninth clock.
- R3: A first byte with a different device code or different select bits gets no acknowledge. No byte after it is acknowledged and no memory strobe is raised until the next start.
- R4: After a write-direction selection (bit 0 = 0), the next byte gives pointer bits 13..8 from its bits 5..0, and bits 7..6 are discarded. The byte after that gives pointer bits 7..0. Both bytes are acknowledged.
- R5: Each data byte received after the two pointer bytes is acknowledged and produces a one-cycle `mem_we` pulse, with `mem_addr` equal to the pointer and `mem_wdata` equal to the byte.
- R6: After a read-direction selection (bit 0 = 1), the byte at the current pointer is read through the memory port and shifted out MSB first. This includes a random read, where a repeated start follows the pointer bytes.
- R7: The pointer increments by one after every byte written or read and wraps from 0x3FFF to 0x0000, never changing the selected device.
- R8: A master NACK after a read byte ends the read. The data line is released and no further `mem_re` is raised until the next start.
- R9: The block changes `sda_oe` only while `scl_i` is low.
- R10: A stop in the middle of a byte aborts it with no write and no pointer change. A start in the middle of a byte restarts selection.
- R11: `mem_we` and `mem_re` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired-AND level) |
| sel_pins | input | 3 | Strapped select bits compared with control byte bits 3..1 |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |

## Verification
Bus-level results are tied to bit slots rather than to clock counts. Each line edge passes a two-stage synchronizer and an edge register, so `sda_oe` moves about four clocks after the master's clock fall. The bench therefore places every data change five clocks into the low phase and samples the line five clocks into the high phase, well clear of that delay. Memory strobes appear within a few clocks of the byte-ending clock fall, and each read byte is latched two clocks after `mem_re`. Strobe counts and captured addresses are compared only after the whole transaction and a stop, so no check sits near a strobe's edge.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } twi_state_e;
endpackage

// File: rtl/twi_cond_detect.sv
module twi_cond_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p, scl_c, sda_c;

  assign scl_c = scl_sr[STAGES-1];
  assign sda_c = sda_sr[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_c;
      sda_p  <= sda_c;
    end
  end

  assign sda_s     = sda_c;
  assign scl_rise  = scl_c & ~scl_p;
  assign scl_fall  = ~scl_c & scl_p;
  assign start_det = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_det  = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/twi_word_addr.sv
module twi_word_addr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_hi,
  input  logic          load_lo,
  input  logic          incr,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] ptr
);
  localparam int HIW = AW - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load_hi) begin
      ptr[AW-1:8] <= byte_in[HIW-1:0];
    end else if (load_lo) begin
      ptr[7:0] <= byte_in;
    end else if (incr) begin
      ptr <= ptr + AW'(1);
    end
  end
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave #(
  parameter int                AW          = 14,
  parameter int                CODE_W      = 4,
  parameter int                SEL_W       = 3,
  parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1010,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] sel_pins,
  input  logic [7:0]       mem_rdata,
  output logic             sda_oe,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             mem_we,
  output logic             mem_re
);
  import twi_pkg::*;

  localparam int SEL_LSB = 8 - CODE_W - SEL_W;

  twi_state_e    state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txreg;
  logic          own_ack, rd_p1;
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr;
  logic          ev_ok, rx_state, fall_decide, rise_mack, ctrl_match;
  logic          rd_issue, wr_issue, load_hi, load_lo;

  twi_cond_detect #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_word_addr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load_hi(load_hi), .load_lo(load_lo),
    .incr(rd_issue | wr_issue), .byte_in(shreg), .ptr(ptr)
  );

  always_comb begin
    ev_ok       = !start_det && !stop_det && (state != ST_IDLE);
    rx_state    = (state == ST_CTRL) || (state == ST_AHI) ||
                  (state == ST_ALO) || (state == ST_WDATA);
    fall_decide = ev_ok && scl_fall && (bitcnt == 4'd8) && !own_ack && rx_state;
    rise_mack   = ev_ok && scl_rise && (bitcnt == 4'd8) && !own_ack &&
                  (state == ST_RDATA);
    ctrl_match  = (shreg[7 -: CODE_W] == DEV_CODE) &&
                  (shreg[SEL_LSB +: SEL_W] == sel_pins);
    rd_issue    = (fall_decide && (state == ST_CTRL) && ctrl_match && shreg[0]) ||
                  (rise_mack && !sda_s);
    wr_issue    = fall_decide && (state == ST_WDATA);
    load_hi     = fall_decide && (state == ST_AHI);
    load_lo     = fall_decide && (state == ST_ALO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      own_ack   <= 1'b0;
      rd_p1     <= 1'b0;
      sda_oe    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      rd_p1  <= mem_re;
      if (rd_p1) txreg <= mem_rdata;
      if (rd_issue) begin
        mem_re   <= 1'b1;
        mem_addr <= ptr;
      end
      if (wr_issue) begin
        mem_we    <= 1'b1;
        mem_addr  <= ptr;
        mem_wdata <= shreg;
      end

      if (start_det) begin
        state   <= ST_CTRL;
        bitcnt  <= '0;
        own_ack <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        own_ack <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            shreg  <= {shreg[6:0], sda_s};
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (rise_mack && sda_s) state <= ST_HOLD;
          end
        end else if (scl_fall) begin
          if (fall_decide) begin
            own_ack <= 1'b1;
            sda_oe  <= 1'b1;
            unique case (state)
              ST_CTRL: begin
                if (!ctrl_match) begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
                end else if (shreg[0]) begin
                  state <= ST_RDATA;
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI:   state <= ST_ALO;
              ST_ALO:   state <= ST_WDATA;
              default:  state <= ST_WDATA;
            endcase
          end else if ((bitcnt == 4'd8) && (state == ST_RDATA)) begin
            sda_oe <= 1'b0;
          end else if (bitcnt == 4'd9) begin
            bitcnt  <= '0;
            own_ack <= 1'b0;
            sda_oe  <= (state == ST_RDATA) ? ~txreg[7] : 1'b0;
          end else if ((state == ST_RDATA) && (bitcnt != 4'd0) && (bitcnt < 4'd8)) begin
            sda_oe <= ~txreg[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr
);
  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) AST_RESET_QUIET: assert (!sda_oe && !mem_we && !mem_re); // R1
  end

  AST_SDA_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R11

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R5

  AST_RE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re); // R11

  AST_RE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> $stable(mem_addr)); // R6
endmodule

bind eeprom_twi_slave twi_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/tb_eeprom_twi_slave.sv
module tb_eeprom_twi_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic [7:0] mem_rdata = '0;
  logic sda_oe, mem_we, mem_re;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0, r9_bad = 0;
  logic [13:0] wr_addr [8];
  logic [7:0]  wr_data [8];
  logic done = 1'b0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  eeprom_twi_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sel_pins(sel),
    .mem_rdata(mem_rdata), .sda_oe(sda_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= pat(mem_addr);
      re_cnt <= re_cnt + 1;
    end
    if (mem_we) begin
      wr_addr[we_cnt % 8] <= mem_addr;
      wr_data[we_cnt % 8] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && (sda_oe !== prev_oe) && scl_m) r9_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic s);
    tick(5); sda_m = b;
    tick(5); scl_m = 1'b1;
    tick(5); s = sda_line;
    tick(5); scl_m = 1'b0;
  endtask

  task automatic do_start();
    tick(5); sda_m = 1'b1;
    tick(5); scl_m = 1'b1;
    tick(5); sda_m = 1'b0;
    tick(5); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    tick(5); sda_m = 1'b0;
    tick(5); scl_m = 1'b1;
    tick(5); sda_m = 1'b1;
    tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
    xfer_bit(1'b1, nack);
  endtask

  task automatic read_byte(input logic mnack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, s);
      b[i] = s;
    end
    xfer_bit(mnack, s);
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
    logic n;
    do_start();
    send_byte({4'b1010, sel, 1'b0}, n); chk("R2 write select ack", n, 0);
    send_byte(hi, n); chk("R4 high pointer ack", n, 0);
    send_byte(lo, n); chk("R4 low pointer ack", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic n;
    logic [7:0] b;
    int w0, r0;
    tick(4);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset strobes", {mem_we, mem_re}, 0);
    rst = 1'b0;
    tick(10);
    chk("R1 after reset sda_oe", sda_oe, 0);

    // R2 / R3: sweep all select values and all device codes
    for (int s = 0; s < 8; s++) begin
      do_start();
      send_byte({4'b1010, s[2:0], 1'b0}, n);
      chk(s == int'(sel) ? "R2 select sweep ack" : "R3 select sweep nack",
          n, (s == int'(sel)) ? 0 : 1);
      do_stop();
    end
    for (int c = 0; c < 16; c++) begin
      do_start();
      send_byte({c[3:0], sel, 1'b0}, n);
      chk(c == 10 ? "R2 code sweep ack" : "R3 code sweep nack", n, (c == 10) ? 0 : 1);
      do_stop();
    end

    // R3: bytes after a mismatch are ignored
    w0 = we_cnt; r0 = re_cnt;
    do_start();
    send_byte({4'b1010, ~sel, 1'b0}, n); chk("R3 mismatch nack", n, 1);
    send_byte(8'h00, n); chk("R3 later byte nack", n, 1);
    send_byte(8'h00, n); chk("R3 later byte nack", n, 1);
    send_byte(8'h42, n); chk("R3 later byte nack", n, 1);
    do_stop();
    chk("R3 no strobes", (we_cnt - w0) + (re_cnt - r0), 0);

    // R4 R5 R7: write with discarded top bits and wrap
    w0 = we_cnt;
    set_ptr(8'hFF, 8'hFE);
    send_byte(8'h11, n); chk("R5 data ack", n, 0);
    send_byte(8'h22, n); chk("R5 data ack", n, 0);
    send_byte(8'h33, n); chk("R5 data ack", n, 0);
    do_stop();
    chk("R5 write count", we_cnt - w0, 3);
    chk("R4 first write addr", wr_addr[w0 % 8], 14'h3FFE);
    chk("R5 first write data", wr_data[w0 % 8], 8'h11);
    chk("R7 second write addr", wr_addr[(w0 + 1) % 8], 14'h3FFF);
    chk("R5 second write data", wr_data[(w0 + 1) % 8], 8'h22);
    chk("R7 wrapped write addr", wr_addr[(w0 + 2) % 8], 14'h0000);
    chk("R5 third write data", wr_data[(w0 + 2) % 8], 8'h33);

    // R6 R8: random read of three bytes
    set_ptr(8'h12, 8'h34);
    r0 = re_cnt;
    do_start();
    send_byte({4'b1010, sel, 1'b1}, n); chk("R6 read select ack", n, 0);
    read_byte(1'b0, b); chk("R6 random read byte0", b, pat(14'h1234));
    read_byte(1'b0, b); chk("R7 random read byte1", b, pat(14'h1235));
    read_byte(1'b1, b); chk("R7 random read byte2", b, pat(14'h1236));
    tick(10);
    chk("R8 released after nack", sda_oe, 0);
    do_stop();
    tick(60);
    chk("R8 read count", re_cnt - r0, 3);

    // R7: read wrap, then current-address read
    set_ptr(8'h3F, 8'hFF);
    do_start();
    send_byte({4'b1010, sel, 1'b1}, n); chk("R6 read select ack", n, 0);
    read_byte(1'b0, b); chk("R7 read at top", b, pat(14'h3FFF));
    read_byte(1'b1, b); chk("R7 read wraps", b, pat(14'h0000));
    do_stop();
    do_start();
    send_byte({4'b1010, sel, 1'b1}, n); chk("R6 current read ack", n, 0);
    read_byte(1'b1, b); chk("R6 current address read", b, pat(14'h0001));
    do_stop();

    // R10: stop mid-byte aborts without write or pointer change
    w0 = we_cnt;
    set_ptr(8'h00, 8'h10);
    for (int i = 0; i < 4; i++) xfer_bit(i[0], n);
    do_stop();
    chk("R10 stop mid-byte no write", we_cnt - w0, 0);
    chk("R10 stop mid-byte sda", sda_oe, 0);
    do_start();
    send_byte({4'b1010, sel, 1'b1}, n); chk("R10 ack after abort", n, 0);
    read_byte(1'b1, b); chk("R10 pointer unchanged", b, pat(14'h0010));
    do_stop();

    // R10: start mid-byte restarts selection
    do_start();
    for (int i = 0; i < 3; i++) xfer_bit(1'b1, n);
    do_start();
    send_byte({4'b1010, sel, 1'b1}, n); chk("R10 restart ack", n, 0);
    read_byte(1'b1, b); chk("R10 restart read", b, pat(14'h0011));
    do_stop();

    chk("R9 sda_oe moved only with scl low", r9_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule